// File: doc/BRIEF.md
# Rate-Compensated Free-Running Counter

This block keeps a 64-bit time base that moves forward only when a slow, already-synchronized reference strobe pulses. Each strobe adds a programmed integer step. Software sets the step to the ratio of a faster oscillator rate to the slow reference rate, rounded up. A trim value then takes one count back from a fixed number of strobes in every window of 100 strobes. Over many strobes, the average rate therefore follows the non-integer ratio to within one hundredth of a count per strobe.

Software controls the block through a small word-addressed register bus: an enable bit, the step, the trim, and the count split into a low and a high word. Reading the low word takes a snapshot of the high word, so two 32-bit reads give one consistent 64-bit value. The full count is also driven on a port for comparator channels elsewhere in the chip.

Top module: `rcfr_counter`

## Requirements
- R1: After a synchronous reset the count, the enable bit, the step, the trim, the read data and the window position are all zero.
- R2: Registers are 32-bit words at byte addresses 0x00 (enable in bit 0), 0x04 (step), 0x08 (trim, 8 bits), 0x0C (count low word) and 0x10 (count high word). Writing 0x00, 0x04 or 0x08 stores the value, and reading the same address returns it zero-extended.
- R3: A strobe that arrives while the block is enabled and falls on an uncompensated position adds the step to the count on that clock edge.
- R4: The window position counts enabled strobes from 0 to 99 and then wraps to 0. A strobe at a position below the trim value is compensated and adds step minus one.
- R5: A trim of 0 gives a plain integer-step counter. A trim of 100 or more compensates every strobe.
- R6: A step of 0 leaves the count unchanged on every strobe, whatever the trim. The compensated add never underflows.
- R7: While the block is disabled, strobes are ignored, the count holds its value and the window position is forced to 0. After the block is enabled again, the compensation pattern starts from position 0.
- R8: A read of 0x0C returns bits 31:0 of the count and also captures bits 63:32. A later read of 0x10 returns the captured bits, even if the count has moved on since.
- R9: Read data is registered and appears on the clock edge where the read strobe is sampled. A read of an unmapped address returns 0.
- R10: The count port always shows the current count.
- R11: With an 8 MHz fast rate and a 32768 Hz reference, the step works out to 245 and the trim to 86. With these values, 100 strobes advance the count by exactly 24414.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Reference strobe, one clock wide per slow tick, already synchronized |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| count_out | output | 64 | Current count, for comparator channels |

## Verification
The main function is swept over a grid of steps (0, 1, 2, 7, 245) and trims (0, 1, 37, 99, 100, 150). The count is checked after exactly one window and again after two and a half windows. These cases separate four behaviours:
- the plain-step path (trim 0);
- partial compensation spread across whole and partial windows;
- full saturation of the trim (100 and above);
- the guard against underflow when the step is 0.

A case that enables, stops part-way through a window and then re-enables, with trim 30, gives different totals depending on whether the window restarts from position 0. A step of 0xFFFFFFFF drives carries into the high word, which shows whether a split read keeps its captured high half after the count has moved on.

// File: rtl/rcfr_pkg.sv
package rcfr_pkg;
  localparam int unsigned BUS_W = 32;

  // Word index taken from byte address bits 4:2
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_STEP   = 3'd1,
    SEL_TRIM   = 3'd2,
    SEL_CNT_LO = 3'd3,
    SEL_CNT_HI = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/rcfr_regs.sv
module rcfr_regs
  import rcfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned TRIM_W = 8,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output logic              en_q,
  output logic [STEP_W-1:0] step_q,
  output logic [TRIM_W-1:0] trim_q,
  output logic [BUS_W-1:0]  rdata
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic            hit;
  reg_sel_e        sel;
  logic [HI_W-1:0] hi_snap;

  // Only word-aligned addresses below 0x20 belong to this block
  assign hit = (addr[ADDR_W-1:5] == '0) && (addr[1:0] == 2'b00);
  assign sel = reg_sel_e'(addr[4:2]);

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      step_q <= '0;
      trim_q <= '0;
    end else if (wr && hit) begin
      case (sel)
        SEL_CTRL: en_q   <= wdata[0];
        SEL_STEP: step_q <= wdata[STEP_W-1:0];
        SEL_TRIM: trim_q <= wdata[TRIM_W-1:0];
        default:  ;
      endcase
    end
  end

  // Read path: a low-word read also captures the high word
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      hi_snap <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (hit) begin
        case (sel)
          SEL_CTRL:   rdata <= BUS_W'(en_q);
          SEL_STEP:   rdata <= BUS_W'(step_q);
          SEL_TRIM:   rdata <= BUS_W'(trim_q);
          SEL_CNT_LO: begin
            rdata   <= count[BUS_W-1:0];
            hi_snap <= count[CNT_W-1:BUS_W];
          end
          SEL_CNT_HI: rdata <= BUS_W'(hi_snap);
          default:    rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rcfr_window.sv
module rcfr_window #(
  parameter int unsigned WINDOW = 100,
  parameter int unsigned TRIM_W = 8,
  localparam int unsigned WIN_W = $clog2(WINDOW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [TRIM_W-1:0] trim,
  output logic [WIN_W-1:0]  win_q,
  output logic              comp
);
  localparam int unsigned CMP_W = (WIN_W > TRIM_W) ? WIN_W : TRIM_W;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      win_q <= '0;
    end else if (tick) begin
      win_q <= (win_q == WIN_W'(WINDOW - 1)) ? '0 : win_q + 1'b1;
    end
  end

  // The first "trim" positions of each window are compensated
  assign comp = CMP_W'(win_q) < CMP_W'(trim);
endmodule

// File: rtl/rcfr_accum.sv
module rcfr_accum #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              comp,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  count_q
);
  logic             dec;
  logic [CNT_W-1:0] inc;

  // Take one count back only when there is a count to take
  assign dec = comp && (step != '0);
  assign inc = CNT_W'(step) - CNT_W'(dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (advance) begin
      count_q <= count_q + inc;
    end
  end
endmodule

// File: rtl/rcfr_counter.sv
module rcfr_counter
  import rcfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned TRIM_W = 8,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WINDOW = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [CNT_W-1:0]  count_out
);
  localparam int unsigned WIN_W = $clog2(WINDOW);

  logic              en_q;
  logic [STEP_W-1:0] step_q;
  logic [TRIM_W-1:0] trim_q;
  logic [WIN_W-1:0]  win_q;
  logic              comp;
  logic [CNT_W-1:0]  count_q;

  rcfr_regs #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .TRIM_W(TRIM_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count_q), .en_q(en_q), .step_q(step_q),
    .trim_q(trim_q), .rdata(bus_rdata)
  );

  rcfr_window #(.WINDOW(WINDOW), .TRIM_W(TRIM_W)) window_i (
    .clk(clk), .rst(rst), .en(en_q), .tick(slow_tick), .trim(trim_q),
    .win_q(win_q), .comp(comp)
  );

  rcfr_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) accum_i (
    .clk(clk), .rst(rst), .advance(en_q && slow_tick), .comp(comp),
    .step(step_q), .count_q(count_q)
  );

  assign count_out = count_q;
endmodule

// File: rtl/rcfr_counter_chk.sv
module rcfr_counter_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned WINDOW = 100,
  localparam int unsigned WIN_W = $clog2(WINDOW)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              tick,
  input logic [WIN_W-1:0]  win,
  input logic [STEP_W-1:0] step,
  input logic [CNT_W-1:0]  count
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en || !tick) |=> $stable(count));

  p_win_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (win == '0));

  p_win_range_r4: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(win) < CNT_W'(WINDOW));

  p_win_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && (CNT_W'(win) == CNT_W'(WINDOW - 1))) |=> (win == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (((count - $past(count)) == CNT_W'($past(step))) ||
                      ((count - $past(count)) == CNT_W'($past(step)) - 1)));

  p_zero_step_r6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && (step == '0)) |=> $stable(count));
endmodule

bind rcfr_counter rcfr_counter_chk #(.CNT_W(CNT_W), .STEP_W(STEP_W), .WINDOW(WINDOW)) chk_i (
  .clk(clk), .rst(rst), .en(en_q), .tick(slow_tick), .win(win_q),
  .step(step_q), .count(count_q)
);

// File: tb/rcfr_counter_tb_top.sv
module rcfr_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] count_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_STEP = 8'h04, A_TRIM = 8'h08,
                         A_LO = 8'h0C, A_HI = 8'h10, A_NONE = 8'h14;

  always #2 clk = ~clk;

  rcfr_counter dut_i (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_out(count_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      slow_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0;
    end
  endtask

  // Expected advance after n enabled ticks starting at window position 0
  function automatic logic [63:0] exp_delta(input int n, input longint step, input int trim);
    int t;
    int r;
    longint comp;
    t = (trim > 100) ? 100 : trim;
    r = n % 100;
    comp = longint'(n / 100) * t + ((r < t) ? r : t);
    if (step == 0) return 64'd0;
    return 64'(longint'(n) * step - comp);
  endfunction

  task automatic restart(input logic [31:0] step, input logic [31:0] trim);
    wr(A_CTRL, 32'd0);
    wr(A_STEP, step);
    wr(A_TRIM, trim);
    wr(A_CTRL, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] base;
    logic [63:0] snap;
    int steps[5] = '{0, 1, 2, 7, 245};
    int trims[6] = '{0, 1, 37, 99, 100, 150};

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 count port", count_out, 64'd0);
    rd(A_CTRL, d); check("R1 enable", 64'(d), 64'd0);
    rd(A_STEP, d); check("R1 step", 64'(d), 64'd0);
    rd(A_TRIM, d); check("R1 trim", 64'(d), 64'd0);
    rd(A_LO, d);   check("R1 low word", 64'(d), 64'd0);

    // R2 register readback; R9 unmapped read
    wr(A_STEP, 32'hA5A5_1234); rd(A_STEP, d); check("R2 step readback", 64'(d), 64'hA5A5_1234);
    wr(A_TRIM, 32'h0000_01C3); rd(A_TRIM, d); check("R2 trim 8-bit readback", 64'(d), 64'h0000_00C3);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R2 enable readback", 64'(d), 64'd1);
    wr(A_CTRL, 32'd0);
    rd(A_NONE, d); check("R9 unmapped read", 64'(d), 64'd0);

    // R7: ticks while disabled are ignored
    base = count_out;
    tick(10);
    check("R7 disabled hold", count_out, base);

    // R3 R4 R5 R6: sweep of step and trim
    foreach (steps[i]) begin
      foreach (trims[j]) begin
        restart(32'(steps[i]), 32'(trims[j]));
        base = count_out;
        tick(100);
        check($sformatf("R4 window step=%0d trim=%0d n=100", steps[i], trims[j]),
              count_out - base, exp_delta(100, steps[i], trims[j]));
        tick(150);
        check($sformatf("R5 R6 R3 step=%0d trim=%0d n=250", steps[i], trims[j]),
              count_out - base, exp_delta(250, steps[i], trims[j]));
      end
    end

    // R7: disable resets the window so the pattern restarts at position 0
    restart(32'd10, 32'd30);
    base = count_out;
    tick(30);
    check("R7 first part", count_out - base, exp_delta(30, 10, 30));
    wr(A_CTRL, 32'd0);
    base = count_out;
    tick(5);
    check("R7 hold while off", count_out, base);
    wr(A_CTRL, 32'd1);
    tick(20);
    check("R7 window restart", count_out - base, exp_delta(20, 10, 30));

    // R8 R10: coherent split read across high-word carries
    restart(32'hFFFF_FFFF, 32'd0);
    base = count_out;
    tick(3);
    snap = count_out;
    check("R10 count port", snap - base, exp_delta(3, 64'hFFFF_FFFF, 0));
    rd(A_LO, d);
    check("R8 low word", 64'(d), 64'(snap[31:0]));
    tick(2);
    rd(A_HI, d);
    check("R8 captured high word", 64'(d), 64'(snap[63:32]));
    snap = count_out;
    rd(A_LO, d);
    rd(A_HI, d);
    check("R8 fresh high word", 64'(d), 64'(snap[63:32]));

    // R11: step and trim worked out from the rates
    begin
      longint osc, ref_hz, st, fr, tr;
      osc = 24_000_000 / 3;
      ref_hz = 32768;
      st = (osc + ref_hz - 1) / ref_hz;
      fr = ((osc * 1000 / ref_hz + 5) / 10) % 100;
      tr = (fr != 0) ? 100 - fr : 0;
      check("R11 step", 64'(st), 64'd245);
      check("R11 trim", 64'(tr), 64'd86);
      restart(32'(st), 32'(tr));
      base = count_out;
      tick(100);
      check("R11 100 ticks", count_out - base, 64'(osc * 100 / ref_hz));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule